// File: doc/BRIEF.md
# ADC Regular-Sequence Scan Controller

This block steps an analog-to-digital converter through a programmed list of input channels. Software sets it up through a small 32-bit register bus: two control registers, three sequence registers that hold up to sixteen packed 5-bit channel slots, a status register, and a data register. The data register returns the most recent 12-bit result.

A sequence can be launched in two ways. Software can set a start bit. Alternatively, the block can watch one of sixteen external trigger lines for a rising edge, a falling edge, or either edge.

The controller talks to the converter through a simple handshake. It issues a one-cycle start pulse together with a channel number. The converter later answers with a one-cycle done pulse carrying the result. The block powers the converter up, waits out a stabilisation interval before the first conversion, and raises an end-of-conversion flag and interrupt.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The registers sit at these offsets: status 0x00, ctrl_a 0x04, ctrl_b 0x08, seq_hi 0x2C, seq_mid 0x30, seq_lo 0x34 and result 0x4C. All of them read zero after reset. The start bit ctrl_b[30] always reads back as zero.
- R2: Each slot k is a 5-bit field. Slots 0 to 5 sit in seq_lo at bit 5k. Slots 6 to 11 sit in seq_mid at bit 5(k-6). Slots 12 to 15 sit in seq_hi at bit 5(k-12). Conversions go out in ascending slot order. Each one is a single-cycle conv_start_o with the slot's channel on conv_chan_o.
- R3: seq_hi[23:20] holds the conversion count minus one. When ctrl_a[8] (scan) is 1, that many plus one slots are converted. When scan is 0, only slot 0 is converted.
- R4: Writing 1 to ctrl_b[30] starts a sequence only if that same write puts 00 in ctrl_b[29:28]. In any other trigger mode the bit has no effect.
- R5: ctrl_b[27:24] selects the ext_trig_i line. ctrl_b[29:28] selects the start condition: 01 starts on a rising edge, 10 on a falling edge and 11 on either edge. Edges on lines that are not selected are ignored.
- R6: ctrl_b[0] powers the converter. While it is 0, start requests are discarded, and clearing it also abandons a running sequence. After it is set, a start request is held pending until STAB_CYCLES clock edges have passed.
- R7: Start requests that arrive while a sequence runs are ignored. After the last slot's result the block returns to idle; there is no continuous mode.
- R8: Every result is written to result[11:0] with bits 31:12 at zero. A new result overwrites an unread one.
- R9: status[1] is the end-of-conversion flag. If ctrl_b[10] is 1 it sets after every result; otherwise it sets only after the last result of the sequence. Reading the result register clears it.
- R10: status[4] sets when a sequence starts. Writing 0 to that bit clears it.
- R11: irq_o is high exactly while status[1] and ctrl_a[5] are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (drives read side effects) |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| ext_trig_i | input | 16 | External trigger lines |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 5 | Channel for the current conversion |
| conv_done_i | input | 1 | One-cycle result strobe from the converter |
| conv_data_i | input | 12 | Conversion result |
| irq_o | output | 1 | End-of-conversion interrupt |

## Verification
The bench sets STAB_CYCLES to 8 and uses a converter model with a five-cycle latency. This makes the stabilisation window short enough to check edge by edge. The five-cycle latency leaves room to put a second trigger edge in the middle of a running sequence. A full sixteen-slot scan reaches every packed field in all three sequence registers. Short three-slot runs are used to cover all four trigger modes, both flag policies, and scan disabled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W   = 8;
  localparam int BUS_W    = 32;
  localparam int RES_W    = 12;
  localparam int CH_W     = 5;
  localparam int MAX_SLOTS = 16;
  localparam int SLOTS_PER_REG = 6;
  localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
  localparam int NUM_TRIG = 16;
  localparam int SEL_W    = $clog2(NUM_TRIG);

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL_A = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL_B = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SEQ_HI = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_SEQ_MID = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SEQ_LO = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_RESULT = 8'h4C;

  localparam int ST_EOC_BIT  = 1;
  localparam int ST_STRT_BIT = 4;
  localparam int CA_IE_BIT   = 5;
  localparam int CA_SCAN_BIT = 8;
  localparam int CB_PWR_BIT  = 0;
  localparam int CB_EACH_BIT = 10;
  localparam int CB_SEL_LSB  = 24;
  localparam int CB_MODE_LSB = 28;
  localparam int CB_SW_BIT   = 30;
  localparam int LEN_LSB     = 20;

  localparam logic [BUS_W-1:0] SEQ_FULL_MASK = 32'h3FFF_FFFF;
  localparam logic [BUS_W-1:0] SEQ_HI_MASK   = 32'h00FF_FFFF;

  typedef enum logic [1:0] {
    TRIG_SOFT = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_REQ,
    SEQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
  import adc_seq_pkg::*;
#(
  parameter int NTRIG = NUM_TRIG,
  parameter int SW    = $clog2(NTRIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTRIG-1:0] trig_i,
  input  logic [SW-1:0]    sel_i,
  input  trig_mode_e       mode_i,
  output logic             edge_o
);
  logic [NTRIG-1:0] trig_q;
  logic cur, prv, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_i;
  end

  assign cur  = trig_i[sel_i];
  assign prv  = trig_q[sel_i];
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;

  always_comb begin
    unique case (mode_i)
      TRIG_RISE: edge_o = rise;
      TRIG_FALL: edge_o = fall;
      TRIG_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_stab_timer.sv
module adc_stab_timer #(
  parameter int STAB_CYCLES = 16,
  parameter int CNT_W = $clog2(STAB_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  output logic ready_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STAB_CYCLES);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!pwr_i)          cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = pwr_i && (cnt_q == LIMIT);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SLOTS = MAX_SLOTS,
  parameter int CHW   = CH_W,
  parameter int IW    = $clog2(SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      go_i,
  input  logic                      abort_i,
  input  logic [SLOTS-1:0][CHW-1:0] slots_i,
  input  logic [IW-1:0]             last_i,
  input  logic                      done_i,
  output logic                      idle_o,
  output logic                      start_o,
  output logic [CHW-1:0]            chan_o,
  output logic                      capture_o,
  output logic                      end_o
);
  seq_state_e    state_q;
  logic [IW-1:0] idx_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (go_i) begin
          state_q <= SEQ_REQ;
          idx_q   <= '0;
          last_q  <= last_i;
        end
        SEQ_REQ: state_q <= SEQ_WAIT;
        SEQ_WAIT: if (done_i) begin
          if (idx_q == last_q) begin
            state_q <= SEQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= SEQ_REQ;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign idle_o    = (state_q == SEQ_IDLE);
  assign start_o   = (state_q == SEQ_REQ);
  assign chan_o    = slots_i[idx_q];
  assign capture_o = (state_q == SEQ_WAIT) && done_i;
  assign end_o     = capture_o && (idx_q == last_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [BUS_W-1:0]    reg_wdata_i,
  output logic [BUS_W-1:0]    reg_rdata_o,
  input  logic [NUM_TRIG-1:0] ext_trig_i,
  output logic                conv_start_o,
  output logic [CH_W-1:0]     conv_chan_o,
  input  logic                conv_done_i,
  input  logic [RES_W-1:0]    conv_data_i,
  output logic                irq_o
);
  logic wr_status, wr_ctrl_a, wr_ctrl_b, wr_hi, wr_mid, wr_lo, rd_result;
  logic scan_q, ie_q, pwr_q, each_q;
  logic [SEL_W-1:0] sel_q;
  trig_mode_e mode_q;
  logic [BUS_W-1:0] seq_hi_q, seq_mid_q, seq_lo_q;
  logic [RES_W-1:0] data_q;
  logic eoc_q, strt_q, pend_q;
  logic pwr_d, sw_req, trig_req, start_req, go, stab_ready, seq_idle;
  logic capture, seq_end;
  logic [SLOT_IDX_W-1:0] last_idx;
  logic [MAX_SLOTS-1:0][CH_W-1:0] slots;

  assign wr_status = reg_we_i && reg_addr_i == OFS_STATUS;
  assign wr_ctrl_a = reg_we_i && reg_addr_i == OFS_CTRL_A;
  assign wr_ctrl_b = reg_we_i && reg_addr_i == OFS_CTRL_B;
  assign wr_hi     = reg_we_i && reg_addr_i == OFS_SEQ_HI;
  assign wr_mid    = reg_we_i && reg_addr_i == OFS_SEQ_MID;
  assign wr_lo     = reg_we_i && reg_addr_i == OFS_SEQ_LO;
  assign rd_result = reg_re_i && reg_addr_i == OFS_RESULT;

  // slot packing: six per register, top register holds the remaining four
  for (genvar k = 0; k < MAX_SLOTS; k++) begin : g_slot
    if (k < SLOTS_PER_REG) begin : g_lo
      assign slots[k] = seq_lo_q[CH_W*k +: CH_W];
    end else if (k < 2*SLOTS_PER_REG) begin : g_mid
      assign slots[k] = seq_mid_q[CH_W*(k-SLOTS_PER_REG) +: CH_W];
    end else begin : g_hi
      assign slots[k] = seq_hi_q[CH_W*(k-2*SLOTS_PER_REG) +: CH_W];
    end
  end

  assign last_idx = scan_q ? seq_hi_q[LEN_LSB +: SLOT_IDX_W] : '0;

  adc_trig_edge #(.NTRIG(NUM_TRIG), .SW(SEL_W)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (ext_trig_i),
    .sel_i  (sel_q),
    .mode_i (mode_q),
    .edge_o (trig_req)
  );

  adc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_i   (pwr_q),
    .ready_o (stab_ready)
  );

  assign pwr_d     = wr_ctrl_b ? reg_wdata_i[CB_PWR_BIT] : pwr_q;
  assign sw_req    = wr_ctrl_b && reg_wdata_i[CB_SW_BIT] &&
                     (reg_wdata_i[CB_MODE_LSB +: 2] == TRIG_SOFT);
  assign start_req = sw_req | trig_req;
  assign go        = pend_q && stab_ready && seq_idle && pwr_d;

  adc_seq_fsm #(.SLOTS(MAX_SLOTS), .CHW(CH_W), .IW(SLOT_IDX_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .abort_i   (~pwr_d),
    .slots_i   (slots),
    .last_i    (last_idx),
    .done_i    (conv_done_i),
    .idle_o    (seq_idle),
    .start_o   (conv_start_o),
    .chan_o    (conv_chan_o),
    .capture_o (capture),
    .end_o     (seq_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q    <= 1'b0;
      ie_q      <= 1'b0;
      pwr_q     <= 1'b0;
      each_q    <= 1'b0;
      sel_q     <= '0;
      mode_q    <= TRIG_SOFT;
      seq_hi_q  <= '0;
      seq_mid_q <= '0;
      seq_lo_q  <= '0;
    end else begin
      if (wr_ctrl_a) begin
        scan_q <= reg_wdata_i[CA_SCAN_BIT];
        ie_q   <= reg_wdata_i[CA_IE_BIT];
      end
      if (wr_ctrl_b) begin
        each_q <= reg_wdata_i[CB_EACH_BIT];
        sel_q  <= reg_wdata_i[CB_SEL_LSB +: SEL_W];
        mode_q <= trig_mode_e'(reg_wdata_i[CB_MODE_LSB +: 2]);
      end
      pwr_q <= pwr_d;
      if (wr_hi)  seq_hi_q  <= reg_wdata_i & SEQ_HI_MASK;
      if (wr_mid) seq_mid_q <= reg_wdata_i & SEQ_FULL_MASK;
      if (wr_lo)  seq_lo_q  <= reg_wdata_i & SEQ_FULL_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
      eoc_q  <= 1'b0;
      strt_q <= 1'b0;
    end else begin
      pend_q <= pwr_d && !go && (pend_q || (start_req && seq_idle));
      if (capture) data_q <= conv_data_i;
      if (seq_end || (capture && each_q)) eoc_q <= 1'b1;
      else if (rd_result)                 eoc_q <= 1'b0;
      else if (wr_status)                 eoc_q <= eoc_q & reg_wdata_i[ST_EOC_BIT];
      if (go)             strt_q <= 1'b1;
      else if (wr_status) strt_q <= strt_q & reg_wdata_i[ST_STRT_BIT];
    end
  end

  assign irq_o = eoc_q & ie_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_STATUS: begin
        reg_rdata_o[ST_EOC_BIT]  = eoc_q;
        reg_rdata_o[ST_STRT_BIT] = strt_q;
      end
      OFS_CTRL_A: begin
        reg_rdata_o[CA_SCAN_BIT] = scan_q;
        reg_rdata_o[CA_IE_BIT]   = ie_q;
      end
      OFS_CTRL_B: begin
        reg_rdata_o[CB_PWR_BIT]            = pwr_q;
        reg_rdata_o[CB_EACH_BIT]           = each_q;
        reg_rdata_o[CB_SEL_LSB +: SEL_W]   = sel_q;
        reg_rdata_o[CB_MODE_LSB +: 2]      = mode_q;
      end
      OFS_SEQ_HI:  reg_rdata_o = seq_hi_q;
      OFS_SEQ_MID: reg_rdata_o = seq_mid_q;
      OFS_SEQ_LO:  reg_rdata_o = seq_lo_q;
      OFS_RESULT:  reg_rdata_o[RES_W-1:0] = data_q;
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_i,
  input logic             eoc_i,
  input logic             strt_i,
  input logic [RES_W-1:0] data_i,
  input logic             ready_i
);
  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i);

  // R6
  start_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ready_i);

  // R8
  result_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_i) |-> $past(done_i));

  // R9
  eoc_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_i) |-> $past(done_i));

  // R10
  strt_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strt_i) |-> start_i);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (conv_start_o),
  .done_i  (conv_done_i),
  .eoc_i   (eoc_q),
  .strt_i  (strt_q),
  .data_i  (data_q),
  .ready_i (stab_ready)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  import adc_seq_pkg::*;
  localparam int STAB = 8;
  localparam int LAT  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] ext_trig = '0;
  logic conv_start, conv_done = 1'b0, irq;
  logic [4:0] conv_chan;
  logic [11:0] conv_data = '0;

  int n_chk = 0, n_err = 0;

  typedef struct packed { logic [4:0] ch; logic irq; } exp_t;
  exp_t exp_q[$];

  adc_seq_ctrl #(.STAB_CYCLES(STAB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ext_trig_i(ext_trig), .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .irq_o(irq)
  );

  function automatic logic [4:0] chn(int i);
    return 5'((i * 7 + 3) % 32);
  endfunction

  function automatic logic [11:0] model(logic [4:0] ch);
    return 12'(int'(ch) * 37 + 5);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic push_exp(logic [4:0] ch, logic ie);
    exp_t e;
    e.ch = ch; e.irq = ie;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    int g = 0;
    while (exp_q.size() != 0 && g < 3000) begin
      @(negedge clk);
      g++;
    end
    repeat (LAT + 6) @(negedge clk);
  endtask

  task automatic clear_flags();
    logic [31:0] d;
    rd(OFS_RESULT, d);
    wr(OFS_STATUS, 32'h0);
  endtask

  // converter model and scoreboard monitor
  initial begin
    int busy = 0;
    logic [4:0] cur_ch = '0;
    logic pend_irq = 1'b0, irq_exp = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      conv_done = 1'b0;
      if (pend_irq) begin
        check("R9/R11 irq after result", {31'b0, irq}, {31'b0, irq_exp});
        pend_irq = 1'b0;
      end
      if (busy > 0) begin
        busy--;
        if (busy == 0) begin
          conv_data = model(cur_ch);
          conv_done = 1'b1;
          pend_irq  = 1'b1;
        end
      end
      if (rst_ni && conv_start) begin
        cur_ch = conv_chan;
        busy = LAT;
        if (exp_q.size() == 0) begin
          check("R7 unexpected conversion start", 32'd1, 32'd0);
          irq_exp = irq;
        end else begin
          e = exp_q.pop_front();
          check("R2 channel order", {27'b0, conv_chan}, {27'b0, e.ch});
          irq_exp = e.irq;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] d, s1, s2, s3;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(OFS_STATUS, d); check("R1 status reset", d, 32'h0);
    rd(OFS_CTRL_B, d); check("R1 ctrl_b reset", d, 32'h0);
    rd(OFS_SEQ_HI, d); check("R1 seq_hi reset", d, 32'h0);
    rd(OFS_RESULT, d); check("R1 result reset", d, 32'h0);
    check("R11 irq reset", {31'b0, irq}, 32'h0);

    // R2 full sixteen-slot scan, R3 length 15
    s1 = '0; s2 = '0; s3 = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < 6)       s3 |= 32'(chn(i)) << (5 * i);
      else if (i < 12) s2 |= 32'(chn(i)) << (5 * (i - 6));
      else             s1 |= 32'(chn(i)) << (5 * (i - 12));
    end
    wr(OFS_SEQ_LO, s3);
    wr(OFS_SEQ_MID, s2);
    wr(OFS_SEQ_HI, s1 | (32'd15 << 20));
    rd(OFS_SEQ_HI, d); check("R1 seq_hi readback", d, s1 | (32'd15 << 20));
    wr(OFS_CTRL_A, 32'h120);
    for (int i = 0; i < 16; i++) push_exp(chn(i), 1'b1);
    // R6 power-up with start: held for the stabilisation window
    wr(OFS_CTRL_B, 32'h4000_0401);
    for (int i = 0; i < STAB; i++) begin
      @(negedge clk);
      check("R6 start held during stabilisation", {31'b0, conv_start}, 32'h0);
    end
    settle();
    check("R3 all sixteen slots converted", exp_q.size(), 0);
    rd(OFS_CTRL_B, d); check("R1 start bit reads zero", d, 32'h401);
    rd(OFS_STATUS, d); check("R9 R10 status after scan", d, 32'h12);
    check("R11 irq with flag and enable", {31'b0, irq}, 32'h1);
    rd(OFS_RESULT, d); check("R8 last result overwrites", d, {20'b0, model(chn(15))});
    rd(OFS_STATUS, d); check("R9 result read clears flag", d, 32'h10);
    wr(OFS_STATUS, 32'h0);
    rd(OFS_STATUS, d); check("R10 write zero clears started", d, 32'h0);

    // R3 scan disabled: slot 0 only; R11 interrupt disabled
    wr(OFS_CTRL_A, 32'h000);
    push_exp(chn(0), 1'b0);
    wr(OFS_CTRL_B, 32'h4000_0001);
    settle();
    rd(OFS_STATUS, d); check("R11 flag set but irq masked", d, 32'h12);
    rd(OFS_RESULT, d); check("R3 scan off converts slot 0", d, {20'b0, model(chn(0))});
    wr(OFS_STATUS, 32'h0);

    // R9 end-of-sequence flag policy, three slots
    wr(OFS_CTRL_A, 32'h120);
    wr(OFS_SEQ_HI, s1 | (32'd2 << 20));
    push_exp(chn(0), 1'b0); push_exp(chn(1), 1'b0); push_exp(chn(2), 1'b1);
    wr(OFS_CTRL_B, 32'h4000_0001);
    settle();
    rd(OFS_RESULT, d); check("R8 three-slot result", d, {20'b0, model(chn(2))});
    clear_flags();

    // R5 rising edge on line 5, R7 edge during run ignored
    wr(OFS_CTRL_B, (32'd1 << 28) | (32'd5 << 24) | 32'h401);
    @(negedge clk); ext_trig[3] = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 unselected line ignored", exp_q.size(), 0);
    push_exp(chn(0), 1'b1); push_exp(chn(1), 1'b1); push_exp(chn(2), 1'b1);
    ext_trig[5] = 1'b1;
    repeat (3) @(negedge clk); ext_trig[5] = 1'b0;
    repeat (2) @(negedge clk); ext_trig[5] = 1'b1;
    settle();
    check("R7 one sequence per start", exp_q.size(), 0);
    clear_flags();
    // R4 software start ignored in edge mode; falling edge ignored in rise mode
    wr(OFS_CTRL_B, (32'd1 << 28) | (32'd5 << 24) | 32'h4000_0401);
    @(negedge clk); ext_trig[5] = 1'b0;
    settle();
    rd(OFS_STATUS, d); check("R4 no start in edge mode", d, 32'h0);

    // R5 falling mode
    wr(OFS_CTRL_B, (32'd2 << 28) | (32'd5 << 24) | 32'h401);
    @(negedge clk); ext_trig[5] = 1'b1;
    settle();
    rd(OFS_STATUS, d); check("R5 rise ignored in fall mode", d, 32'h0);
    push_exp(chn(0), 1'b1); push_exp(chn(1), 1'b1); push_exp(chn(2), 1'b1);
    @(negedge clk); ext_trig[5] = 1'b0;
    settle();
    rd(OFS_STATUS, d); check("R5 fall mode started", d, 32'h12);
    clear_flags();

    // R5 both edges
    wr(OFS_CTRL_B, (32'd3 << 28) | (32'd5 << 24) | 32'h401);
    push_exp(chn(0), 1'b1); push_exp(chn(1), 1'b1); push_exp(chn(2), 1'b1);
    @(negedge clk); ext_trig[5] = 1'b1;
    settle();
    push_exp(chn(0), 1'b1); push_exp(chn(1), 1'b1); push_exp(chn(2), 1'b1);
    @(negedge clk); ext_trig[5] = 1'b0;
    settle();
    check("R5 both edges each started", exp_q.size(), 0);
    clear_flags();

    // R6 power off: start discarded
    wr(OFS_CTRL_B, 32'h4000_0000);
    settle();
    rd(OFS_STATUS, d); check("R6 no start while unpowered", d, 32'h0);
    wr(OFS_CTRL_B, 32'h0000_0401);
    repeat (STAB + 6) @(negedge clk);
    rd(OFS_STATUS, d); check("R6 power-up alone starts nothing", d, 32'h0);

    check("R7 no pending conversions", exp_q.size(), 0);
    finish_run();
  end
endmodule